// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Bank

This block gathers the interrupt events of a multi-channel DMA controller and turns them into a single interrupt line. It handles five kinds of event: whole transfer finished, block finished, source-side transaction finished, destination-side transaction finished, and error. Each kind has its own set of registers:

- a raw status register, set by one-cycle event pulses from the channels;
- a mask register, where a 1 lets the interrupt through;
- a masked status view, which is raw AND mask.

Software reaches the bank through a simple bus port. Reads are combinational and decode the current address. Writes take effect on the clock edge. The mask register takes a write word with two fields: the new mask values in bits [7:0], and a per-bit write-enable field in bits [15:8]. Only bits whose enable is set change. So one channel's mask can be set or cleared without a read-modify-write. Raw status bits are cleared by writing ones to a separate clear register. The OR of every masked bit across all five kinds is registered and driven out as `irq_o`.

The channel count is a parameter, 1 to 8, with a default of 2. The reset input is asserted asynchronously and released through a two-stage synchronizer. The bank therefore leaves reset two clock edges after `rst_n` rises.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every mask bit and every raw status bit is 0, every read returns 0, `stat_o` is 0 and `irq_o` is 0.
- R2: A bus write to the mask register of kind t (offset 0x310 + 8·t, with kinds ordered transfer=0, block=1, source=2, destination=3, error=4) writes mask bit n from `bus_wdata[n]` only when `bus_wdata[8+n]` is 1. Every mask bit whose enable is 0 keeps its value.
- R3: A mask write whose enable field `bus_wdata[15:8]` is all zero leaves the whole mask register unchanged, whatever bits [7:0] hold.
- R4: Reading a mask register returns the mask bits in `bus_rdata[NUM_CH-1:0]` and 0 in all other bits.
- R5: A 1 on `evt_i[t*NUM_CH+n]` for one cycle sets raw bit n of kind t on the next edge, whether or not that bit is masked. Raw status of kind t reads at 0x2C0 + 8·t.
- R6: A write to the clear register of kind t (0x338 + 8·t) clears each raw bit n of kind t for which `bus_wdata[n]` is 1, and leaves the others alone. Clear registers read as 0.
- R7: When an event pulse and a clear for the same raw bit fall in the same cycle, the bit ends up set.
- R8: The masked status of kind t is raw AND mask. It appears on `stat_o[t*NUM_CH +: NUM_CH]` in the cycle after the state changes, and reads at 0x2E8 + 8·t.
- R9: `irq_o` equals the OR of all masked status bits of all kinds as they stood one clock earlier.
- R10: A read of any offset not listed in R2, R5, R6 or R8 returns 0, and a write to such an offset changes no register.
- R11: A write to one kind's mask or clear register changes no register of any other kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for `bus_addr` / `bus_wdata` |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| evt_i | input | 5·NUM_CH | Per-kind, per-channel event pulses, kind t at [t·NUM_CH +: NUM_CH] |
| stat_o | output | 5·NUM_CH | Masked status, same layout as `evt_i` |
| irq_o | output | 1 | Registered OR of all masked status bits |

## Verification
Two things can land on the same raw bit in one cycle: a channel event and a software clear. The bench drives a clear word over a raw bit while its event pulse is high, and expects the bit to read back as set (R7). It also writes a mask in the same cycle that an event for that bit arrives. It then follows `stat_o` and the one-cycle-late `irq_o` through the next two cycles. A behavioural model in the bench tracks raw, mask and interrupt state every clock and is compared against the design on every cycle, including a run of random accesses and events.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NKIND   = 5;
  localparam int WE_LSB  = 8;
  localparam int STRIDE  = 8;
  localparam int RAW_BASE  = 'h2C0;
  localparam int STAT_BASE = 'h2E8;
  localparam int MASK_BASE = 'h310;
  localparam int CLR_BASE  = 'h338;

  typedef enum logic [2:0] {
    KIND_XFER  = 3'd0,
    KIND_BLOCK = 3'd1,
    KIND_SRCT  = 3'd2,
    KIND_DSTT  = 3'd3,
    KIND_ERR   = 3'd4
  } irq_kind_e;

  typedef struct packed {
    logic [NKIND-1:0] mask_wr;
    logic [NKIND-1:0] clr_wr;
    logic [NKIND-1:0] mask_rd;
    logic [NKIND-1:0] raw_rd;
    logic [NKIND-1:0] stat_rd;
    logic             mapped;
  } dec_t;
endpackage

// File: rtl/dma_irq_rst_sync.sv
module dma_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output dec_t              dec
);
  always_comb begin
    dec = '0;
    for (int t = 0; t < NKIND; t++) begin
      if (int'(addr) == MASK_BASE + t*STRIDE) begin
        dec.mask_rd[t] = 1'b1;
        dec.mask_wr[t] = wr;
      end
      if (int'(addr) == CLR_BASE + t*STRIDE) begin
        dec.clr_wr[t] = wr;
        dec.mapped    = 1'b1;
      end
      if (int'(addr) == RAW_BASE + t*STRIDE)  dec.raw_rd[t]  = 1'b1;
      if (int'(addr) == STAT_BASE + t*STRIDE) dec.stat_rd[t] = 1'b1;
    end
    dec.mapped = dec.mapped | (|dec.mask_rd) | (|dec.raw_rd) | (|dec.stat_rd);
  end
endmodule

// File: rtl/dma_irq_kind_slice.sv
module dma_irq_kind_slice
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              mask_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] masked
);
  logic [NUM_CH-1:0] raw_d, mask_d, clr_bits;
  logic              raw_en, mask_en;

  assign clr_bits = clr_wr ? wdata[NUM_CH-1:0] : '0;
  assign raw_en   = (|evt) | clr_wr;
  assign mask_en  = mask_wr;

  always_comb begin
    raw_d = (raw_q & ~clr_bits) | evt;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    always_comb begin
      mask_d[n] = wdata[WE_LSB+n] ? wdata[n] : mask_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign masked = raw_q & mask_q;

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

  // R5
  raw_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((raw_q & ~$past(raw_q) & ~$past(evt)) == '0));
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] masked_all,
  output logic         irq_q
);
  logic irq_d;

  assign irq_d = |masked_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R9
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_q == $past(|masked_all)));
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NKIND*NUM_CH-1:0]  evt_i,
  output logic [NKIND*NUM_CH-1:0]  stat_o,
  output logic                     irq_o
);
  localparam int TOT = NKIND * NUM_CH;

  if (NUM_CH < 1 || NUM_CH > WE_LSB) begin : g_bad_cfg
    $error("dma_irq_bank: NUM_CH must be 1..8");
  end

  logic rst_sn;
  dec_t dec;
  logic [NUM_CH-1:0] raw_v  [NKIND];
  logic [NUM_CH-1:0] mask_v [NKIND];
  logic [NUM_CH-1:0] msk_v  [NKIND];

  dma_irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .dec  (dec)
  );

  for (genvar t = 0; t < NKIND; t++) begin : g_kind
    dma_irq_kind_slice #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_sn),
      .evt     (evt_i[t*NUM_CH +: NUM_CH]),
      .mask_wr (dec.mask_wr[t]),
      .clr_wr  (dec.clr_wr[t]),
      .wdata   (bus_wdata),
      .raw_q   (raw_v[t]),
      .mask_q  (mask_v[t]),
      .masked  (msk_v[t])
    );
    assign stat_o[t*NUM_CH +: NUM_CH] = msk_v[t];
  end

  dma_irq_combine #(.W(TOT)) u_comb (
    .clk        (clk),
    .rst_n      (rst_sn),
    .masked_all (stat_o),
    .irq_q      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NKIND; t++) begin
      if (dec.mask_rd[t]) bus_rdata[NUM_CH-1:0] = bus_rdata[NUM_CH-1:0] | mask_v[t];
      if (dec.raw_rd[t])  bus_rdata[NUM_CH-1:0] = bus_rdata[NUM_CH-1:0] | raw_v[t];
      if (dec.stat_rd[t]) bus_rdata[NUM_CH-1:0] = bus_rdata[NUM_CH-1:0] | msk_v[t];
    end
  end

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !dec.mapped |-> (bus_rdata == '0));

  // R4
  mask_rd_upper_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (|dec.mask_rd) |-> ((bus_rdata >> NUM_CH) == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sn |-> (stat_o == '0 && !irq_o));
endmodule

// File: tb/dma_irq_bank_test.sv
module dma_irq_bank_test;
  localparam int N = 2;
  localparam int K = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [K*N-1:0] evt_i = '0;
  logic [K*N-1:0] stat_o;
  logic          irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [N-1:0] m_mask [K];
  logic [N-1:0] m_raw  [K];
  logic         m_irq;
  bit           m_live;

  always #4ns clk = ~clk;

  dma_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(logic [11:0] a);
    logic [31:0] r;
    r = '0;
    for (int t = 0; t < K; t++) begin
      if (a == 12'(12'h310 + 8*t)) r[N-1:0] = m_mask[t];
      if (a == 12'(12'h2C0 + 8*t)) r[N-1:0] = m_raw[t];
      if (a == 12'(12'h2E8 + 8*t)) r[N-1:0] = m_raw[t] & m_mask[t];
    end
    return r;
  endfunction

  function automatic logic [K*N-1:0] model_stat();
    logic [K*N-1:0] s;
    for (int t = 0; t < K; t++) s[t*N +: N] = m_raw[t] & m_mask[t];
    return s;
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [K*N-1:0] e, input string tag);
    logic [K*N-1:0] s_old;
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_i = e;
    #1;
    check32(tag, "rdata", bus_rdata, model_read(a));
    check32(tag, "stat_o", 32'(stat_o), 32'(model_stat()));
    check32(tag, "irq_o", 32'(irq_o), 32'(m_irq));
    @(posedge clk);
    if (m_live) begin
      s_old = model_stat();
      m_irq = |s_old;
      for (int t = 0; t < K; t++) begin
        if (wr && a == 12'(12'h338 + 8*t)) m_raw[t] = m_raw[t] & ~d[N-1:0];
        m_raw[t] = m_raw[t] | e[t*N +: N];
        if (wr && a == 12'(12'h310 + 8*t))
          for (int n = 0; n < N; n++) if (d[8+n]) m_mask[t][n] = d[n];
      end
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b0, a, 32'h0, '0, tag);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < K; t++) begin m_mask[t] = '0; m_raw[t] = '0; end
    m_irq = 1'b0; m_live = 0;
    @(negedge clk);
    // R1: reset state, stimulus ignored while held
    cyc(1'b1, 12'h310, 32'h0303, '1, "R1");
    rd(12'h310, "R1");
    rd(12'h2C0, "R1");
    rst_n = 1'b1;
    rd(12'h2E8, "R1");
    rd(12'h318, "R1");
    m_live = 1;
    rd(12'h330, "R1");
    // R5: raw sets even when masked
    cyc(1'b0, 12'h2C0, 0, 10'b01, "R5");
    rd(12'h2C0, "R5");
    rd(12'h2E8, "R8");
    // R2: enable bit 8 writes bit 0 only
    cyc(1'b1, 12'h310, 32'h0101, '0, "R2");
    rd(12'h310, "R4");
    rd(12'h2E8, "R8");
    rd(12'h2E8, "R9");
    // R3: empty enable field
    cyc(1'b1, 12'h310, 32'h00FE, '0, "R3");
    cyc(1'b1, 12'h310, 32'h0000, '0, "R3");
    rd(12'h310, "R3");
    // R2: set bit1, then clear bit0 alone
    cyc(1'b1, 12'h310, 32'h0202, '0, "R2");
    rd(12'h310, "R2");
    cyc(1'b1, 12'h310, 32'h0100, '0, "R2");
    rd(12'h310, "R2");
    rd(12'h2E8, "R9");
    // R11: other kind mask, enables beyond channel count, R4 upper bits zero
    cyc(1'b1, 12'h318, 32'hFFFF_FFFF, '0, "R11");
    rd(12'h318, "R4");
    rd(12'h310, "R11");
    // R5/R8: events on every kind
    cyc(1'b0, 12'h2C8, 0, '1, "R5");
    for (int t = 0; t < K; t++) begin
      rd(12'(12'h2C0 + 8*t), "R5");
      rd(12'(12'h2E8 + 8*t), "R8");
    end
    // R6: clear bit 0 of kind 0 only; clear reads zero
    cyc(1'b1, 12'h338, 32'h1, '0, "R6");
    rd(12'h2C0, "R6");
    rd(12'h338, "R6");
    rd(12'h2C8, "R11");
    // R7: clear and event on the same bit together
    cyc(1'b1, 12'h340, 32'h3, 10'b01 << N, "R7");
    rd(12'h2C8, "R7");
    rd(12'h2F0, "R7");
    // mask write coinciding with an event
    cyc(1'b1, 12'h320, 32'h0101, 10'b01 << (2*N), "R8");
    rd(12'h2F8, "R8");
    rd(12'h2F8, "R9");
    // R10: unmapped offsets
    cyc(1'b1, 12'h400, 32'hFFFF_FFFF, '0, "R10");
    cyc(1'b1, 12'h314, 32'hFFFF_FFFF, '0, "R10");
    cyc(1'b1, 12'h33C, 32'hFFFF_FFFF, '0, "R10");
    rd(12'h400, "R10");
    rd(12'h314, "R10");
    rd(12'h310, "R10");
    rd(12'h2C0, "R10");
    // R9: drain all, then only error kind drives irq
    for (int t = 0; t < K; t++) cyc(1'b1, 12'(12'h338 + 8*t), 32'hFF, '0, "R6");
    rd(12'h000, "R9");
    rd(12'h000, "R9");
    cyc(1'b1, 12'h330, 32'h0202, '0, "R9");
    cyc(1'b0, 12'h000, 0, 10'b10 << (4*N), "R9");
    rd(12'h300, "R9");
    rd(12'h300, "R9");
    cyc(1'b1, 12'h358, 32'h2, '0, "R9");
    rd(12'h300, "R9");
    rd(12'h300, "R9");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int t, kind;
      t = $urandom_range(0, K-1);
      kind = $urandom_range(0, 4);
      case (kind)
        0: a = 12'(12'h310 + 8*t);
        1: a = 12'(12'h338 + 8*t);
        2: a = 12'(12'h2C0 + 8*t);
        3: a = 12'(12'h2E8 + 8*t);
        default: a = 12'($urandom_range(0, 4095));
      endcase
      cyc(1'($urandom_range(0, 1)), a, $urandom,
          ($urandom_range(0, 3) == 0) ? 10'($urandom) : '0, "R11");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule